// File: doc/BRIEF.md
# Selectable Burst Address Sequencer

This block generates the two low address bits of a four-beat burst. A load pulse captures a 2-bit start address and restarts the burst. Each later cycle in which the active-low advance input is sampled low moves the output to the next beat. When advance is high, the output holds.

A static mode input picks one of two beat orders. In interleaved order, each beat address is the start address XOR the beat number. In linear order, each beat address is the start address plus the beat number, modulo four. After the fourth beat the sequence wraps back to the start address.

The block keeps the start address and a beat count in registers, and forms the output address from them. A memory controller places the output beside the upper address bits it holds itself.

Top module: `burst_seq_gen`

## Requirements
- R1: While rst_ni is low, and in the first cycle after it rises, addr_o and beat_o are both 2'b00.
- R2: load_i high at a rising edge makes addr_o equal the start_i value sampled at that edge, and beat_o equal 0, from that edge on.
- R3: With load_i low and adv_ni low at a rising edge, beat_o increases by one, modulo four.
- R4: With load_i low and adv_ni high at a rising edge, addr_o and beat_o keep their values.
- R5: With mode_i = 1 (interleaved), addr_o equals the loaded start XOR beat_o. Starting from 00, 01, 10 and 11, the beats are 00-01-10-11, 01-00-11-10, 10-11-00-01 and 11-10-01-00.
- R6: With mode_i = 0 (linear), addr_o equals the loaded start plus beat_o, modulo four. Starting from 00, 01, 10 and 11, the beats are 00-01-10-11, 01-10-11-00, 10-11-00-01 and 11-00-01-10.
- R7: A fourth advance after a load returns beat_o to 0 and addr_o to the start address.
- R8: When load_i is high and adv_ni is low at the same edge, the load takes effect: addr_o becomes the new start and beat_o becomes 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; all state changes on the rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Captures start_i and restarts the burst |
| start_i | input | 2 | Start address captured on load |
| adv_ni | input | 1 | Advance to the next beat, active low |
| mode_i | input | 1 | Beat order: 1 = interleaved, 0 = linear; held static |
| addr_o | output | 2 | Low address bits for the current beat |
| beat_o | output | 2 | Index of the current beat, 0 to 3 |

## Verification
Load and advance can both be active at the same rising edge. Each collision case is set up in the middle of a burst, so that a step and a restart would give different results. In one case the beat count is nonzero and the new start address differs from the old one; in the other, the collision comes when the beat count is 3, just before a wrap. Each case is judged by checking, after the edge, that addr_o equals the new start address and beat_o is 0, and that the next advance produces the second beat of the new burst.

// File: rtl/burst_pkg.sv
package burst_pkg;
  typedef enum logic {
    ORDER_LINEAR     = 1'b0,
    ORDER_INTERLEAVE = 1'b1
  } order_e;
endpackage

// File: rtl/burst_beat_cnt.sv
module burst_beat_cnt #(
  parameter int unsigned CNT_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] start_i,
  input  logic             adv_ni,
  output logic [CNT_W-1:0] base_o,
  output logic [CNT_W-1:0] beat_o
);
  logic [CNT_W-1:0] base_q, beat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      beat_q <= '0;
    end else if (load_i) begin
      base_q <= start_i;
      beat_q <= '0;
    end else if (!adv_ni) begin
      beat_q <= beat_q + 1'b1;
    end
  end

  assign base_o = base_q;
  assign beat_o = beat_q;

  p_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (beat_o == '0) && (base_o == $past(start_i)));
  p_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !adv_ni) |=> beat_o == CNT_W'($past(beat_o) + 1'b1));
  p_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && adv_ni) |=> $stable(beat_o) && $stable(base_o));
  p_wrap_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !adv_ni && (&beat_o)) |=> beat_o == '0);
  p_load_wins_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !adv_ni) |=> beat_o == '0);
endmodule

// File: rtl/burst_addr_map.sv
module burst_addr_map
  import burst_pkg::*;
#(
  parameter int unsigned CNT_W = 2
) (
  input  logic             mode_i,
  input  logic [CNT_W-1:0] base_i,
  input  logic [CNT_W-1:0] beat_i,
  output logic [CNT_W-1:0] addr_o
);
  logic [CNT_W-1:0] ilv_addr, lin_addr;

  // interleaved order is a bitwise flip, so each bit stands alone
  for (genvar b = 0; b < CNT_W; b++) begin : g_ilv
    assign ilv_addr[b] = base_i[b] ^ beat_i[b];
  end

  assign lin_addr = base_i + beat_i;

  always_comb begin
    if (order_e'(mode_i) == ORDER_INTERLEAVE) addr_o = ilv_addr;
    else                                      addr_o = lin_addr;
  end
endmodule

// File: rtl/burst_seq_gen.sv
module burst_seq_gen #(
  parameter int unsigned CNT_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] start_i,
  input  logic             adv_ni,
  input  logic             mode_i,
  output logic [CNT_W-1:0] addr_o,
  output logic [CNT_W-1:0] beat_o
);
  logic [CNT_W-1:0] base;

  burst_beat_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load_i),
    .start_i(start_i),
    .adv_ni (adv_ni),
    .base_o (base),
    .beat_o (beat_o)
  );

  burst_addr_map #(.CNT_W(CNT_W)) u_map (
    .mode_i (mode_i),
    .base_i (base),
    .beat_i (beat_o),
    .addr_o (addr_o)
  );

  p_load_addr_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> addr_o == $past(start_i));
  p_load_wins_addr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !adv_ni) |=> addr_o == $past(start_i));
endmodule

// File: tb/burst_seq_gen_tb_top.sv
module burst_seq_gen_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       load_i = 1'b0;
  logic [1:0] start_i = 2'b00;
  logic       adv_ni = 1'b1;
  logic       mode_i = 1'b1;
  logic [1:0] addr_o, beat_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  burst_seq_gen dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load_i), .start_i(start_i),
    .adv_ni(adv_ni), .mode_i(mode_i), .addr_o(addr_o), .beat_o(beat_o)
  );

  function automatic logic [1:0] exp_addr(logic m, logic [1:0] s, logic [1:0] k);
    return m ? (s ^ k) : 2'(s + k);
  endfunction

  task automatic check(string req, logic [1:0] a_exp, logic [1:0] b_exp);
    checks++;
    if (addr_o !== a_exp || beat_o !== b_exp) begin
      failures++;
      $display("FAIL %s addr=%b beat=%b expected addr=%b beat=%b",
               req, addr_o, beat_o, a_exp, b_exp);
    end
  endtask

  // drive at the falling edge, sample 1 ns after the next rising edge
  task automatic cyc(logic ld, logic [1:0] s, logic advn);
    @(negedge clk_i);
    load_i = ld; start_i = s; adv_ni = advn;
    @(posedge clk_i); #1;
  endtask

  task automatic t_reset();
    check("R1", 2'b00, 2'b00);
    @(negedge clk_i); rst_ni = 1'b1;
    @(posedge clk_i); #1;
    check("R1", 2'b00, 2'b00);
  endtask

  task automatic t_sequence(logic m, logic [1:0] s);
    string req = m ? "R5" : "R6";
    mode_i = m;
    cyc(1'b1, s, 1'b1);
    check("R2", s, 2'b00);
    for (int k = 1; k < 4; k++) begin
      cyc(1'b0, 2'b00, 1'b0);
      check(req, exp_addr(m, s, 2'(k)), 2'(k));
    end
    cyc(1'b0, 2'b00, 1'b0);
    check("R7", s, 2'b00);
  endtask

  task automatic t_hold();
    mode_i = 1'b0;
    cyc(1'b1, 2'b10, 1'b1);
    cyc(1'b0, 2'b00, 1'b0);
    for (int k = 0; k < 3; k++) begin
      cyc(1'b0, 2'b01, 1'b1);
      check("R4", 2'b11, 2'b01);
    end
    cyc(1'b0, 2'b00, 1'b0);
    check("R3", 2'b00, 2'b10);
  endtask

  task automatic t_collide();
    mode_i = 1'b1;
    cyc(1'b1, 2'b01, 1'b1);
    cyc(1'b0, 2'b00, 1'b0);
    cyc(1'b0, 2'b00, 1'b0);
    cyc(1'b1, 2'b10, 1'b0);
    check("R8", 2'b10, 2'b00);
    cyc(1'b0, 2'b00, 1'b0);
    check("R8", 2'b11, 2'b01);
    // collision at beat 3, just before a wrap
    mode_i = 1'b0;
    cyc(1'b1, 2'b11, 1'b1);
    for (int k = 0; k < 3; k++) cyc(1'b0, 2'b00, 1'b0);
    check("R3", 2'b10, 2'b11);
    cyc(1'b1, 2'b01, 1'b0);
    check("R8", 2'b01, 2'b00);
    cyc(1'b0, 2'b00, 1'b0);
    check("R8", 2'b10, 2'b01);
  endtask

  task automatic t_reset_mid();
    cyc(1'b1, 2'b11, 1'b1);
    cyc(1'b0, 2'b00, 1'b0);
    @(negedge clk_i); rst_ni = 1'b0; #1;
    check("R1", 2'b00, 2'b00);
    @(negedge clk_i); rst_ni = 1'b1; adv_ni = 1'b1;
    @(posedge clk_i); #1;
    check("R1", 2'b00, 2'b00);
  endtask

  initial begin
    t_reset();
    for (int m = 0; m < 2; m++)
      for (int s = 0; s < 4; s++)
        t_sequence(1'(m), 2'(s));
    t_hold();
    t_collide();
    t_reset_mid();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule